// File: doc/BRIEF.md
# Variable-Length PHY Header Parser

This block sits on the receive side of a packet radio, after sync-word detection. It takes the frame as a stream of bytes and decodes the PHY header that opens each frame. The decoded length then counts off the rest of the frame. Each byte arrives with a valid strobe. The first byte of a frame also carries a start-of-frame strobe. Within each byte, bit 0 is the bit that came first over the air.

The block supports two header formats, selected per frame by a mode input that is sampled at start-of-frame:

- **Short format (mode 0).** A single header byte holds a 7-bit length, read least significant bit first.
- **Long format (mode 1).** A 16-bit header holds an 11-bit length, with both bits and bytes taken most significant first. The long header also holds two selector bits: one chooses the checksum size and one enables data whitening. Downstream checksum and de-whitening logic reads these selectors from the block's outputs.

The length counts the checksum bytes. No offset is added to it. A length that is too large for the mode, or too small to hold the selected checksum, is reported as an error, and the frame is dropped. Otherwise the block counts payload bytes and marks the last one with end-of-frame.

Top module: `phr_len_parser`

## Requirements
- R1: While rst_ni is low, and after it is released, len_o, cnt_o, len_vld_o, len_err_o, eof_o, pay_vld_o, fcs2_o and whiten_o are all 0.
- R2: In mode 0, the byte that carries sof_i is the whole header. Its bits [6:0] are the length and bit 7 is ignored. One clock after that byte, len_vld_o pulses for one cycle, with len_o = length, fcs2_o = 1 and whiten_o = 0.
- R3: In mode 1, the header is byte h0 (with sof_i) followed by byte h1, and header bit k is h0[k] for k<8 and h1[k-8] otherwise. The fields are:
  - bit 3 is fcs2_o (1 selects a 2-byte checksum, 0 a 4-byte checksum);
  - bit 4 is whiten_o;
  - bits 5..15 are the length, with bit 5 as the length MSB and bit 15 as the LSB;
  - bits 0..2 are ignored.
  One clock after h1, len_vld_o pulses with these values.
- R4: A length below the checksum size (2 when fcs2 is set, else 4) is an error. So is a length above MAX_LEN1 in mode 0 or MAX_LEN2 in mode 1. On an error, len_err_o pulses instead of len_vld_o, len_o, fcs2_o and whiten_o keep their old values, and later bytes without sof_i are ignored.
- R5: After a good header, each valid payload byte raises pay_vld_o for one cycle in the next cycle, and cnt_o then shows the number of payload bytes received so far.
- R6: eof_o pulses together with pay_vld_o for the payload byte whose count equals len_o. The block then ignores bytes without sof_i, and cnt_o holds its value.
- R7: A cycle with valid_i low changes no state. cnt_o holds, and no strobe rises in the next cycle.
- R8: A byte with sof_i always starts a new header, in any state, and the current frame is dropped. If it falls on what would have been the last payload byte, eof_o stays low, and cnt_o returns to 0.
- R9: In the idle state, bytes without sof_i are ignored. No strobe rises and cnt_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Header format, sampled with sof_i: 0 short, 1 long |
| valid_i | input | 1 | byte_i holds a byte this cycle |
| sof_i | input | 1 | First byte of a frame (qualified by valid_i) |
| byte_i | input | 8 | Received byte, bit 0 first on air |
| len_o | output | LW (11) | Decoded length, including checksum bytes |
| len_vld_o | output | 1 | One-cycle pulse: header accepted |
| len_err_o | output | 1 | One-cycle pulse: header rejected |
| fcs2_o | output | 1 | 1 selects a 2-byte checksum, 0 a 4-byte checksum |
| whiten_o | output | 1 | Payload whitening enabled |
| pay_vld_o | output | 1 | One-cycle pulse per accepted payload byte |
| cnt_o | output | LW (11) | Payload bytes received in the current frame |
| eof_o | output | 1 | One-cycle pulse on the last payload byte |

## Verification
Two functions can meet in one cycle: the closing byte of a frame, which would raise end-of-frame, and a start-of-frame, which opens a new header. The bench provokes this by asserting sof_i on the byte that would have matched the length. The bench then requires that eof_o stays low, that cnt_o returns to zero and that the new header is decoded. A second test raises sof_i in mid-payload, and a third raises it between the two bytes of a long header. Both are judged the same way.

// File: rtl/phr_pkg.sv
package phr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR2 = 2'd1,
    ST_PAY  = 2'd2
  } phr_st_e;

  localparam int unsigned FCS_SHORT = 2;
  localparam int unsigned FCS_LONG  = 4;
  localparam int unsigned HDR2_LEN_LSB_POS = 5;
endpackage

// File: rtl/phr_hdr_decode.sv
module phr_hdr_decode
  import phr_pkg::*;
#(
  parameter int LEN1_W   = 7,
  parameter int LEN2_W   = 11,
  parameter int MAX_LEN1 = 127,
  parameter int MAX_LEN2 = 2047,
  localparam int LW = (LEN2_W > LEN1_W) ? LEN2_W : LEN1_W
) (
  input  logic          mode_i,
  input  logic [7:0]    b0_i,
  input  logic [7:0]    b1_i,
  output logic [LW-1:0] len_o,
  output logic          fcs2_o,
  output logic          whiten_o,
  output logic          err_o
);
  localparam int HW = 16;

  logic [HW-1:0] hdr;
  logic [LW-1:0] len_short, len_long;
  logic [LW:0]   max_len, min_len;

  assign hdr = {b1_i, b0_i};

  always_comb begin
    len_short = '0;
    len_short[LEN1_W-1:0] = b0_i[LEN1_W-1:0];
  end

  // long-format length is MSB first on air: header bit 5 is the length MSB
  always_comb begin
    len_long = '0;
    for (int j = 0; j < LEN2_W; j++) begin
      len_long[LEN2_W-1-j] = hdr[HDR2_LEN_LSB_POS + j];
    end
  end

  always_comb begin
    if (mode_i) begin
      len_o    = len_long;
      fcs2_o   = hdr[3];
      whiten_o = hdr[4];
      max_len  = (LW+1)'(MAX_LEN2);
    end else begin
      len_o    = len_short;
      fcs2_o   = 1'b1;
      whiten_o = 1'b0;
      max_len  = (LW+1)'(MAX_LEN1);
    end
    min_len = fcs2_o ? (LW+1)'(FCS_SHORT) : (LW+1)'(FCS_LONG);
    err_o   = ({1'b0, len_o} > max_len) || ({1'b0, len_o} < min_len);
  end

  always_comb begin
    a_r2_short_fixed_sel: assert (mode_i || (fcs2_o && !whiten_o));
  end
endmodule

// File: rtl/phr_pay_cnt.sv
module phr_pay_cnt #(
  parameter int LW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [LW-1:0] len_i,
  output logic [LW-1:0] cnt_o,
  output logic          last_o
);
  logic [LW-1:0] cnt_q, cnt_nx;

  assign cnt_nx = cnt_q + LW'(1);
  assign last_o = inc_i && (cnt_nx == len_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_nx;
  end

  a_r5_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inc_i) && !$past(clr_i) |-> cnt_q == $past(cnt_q) + LW'(1));
  a_r8_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/phr_len_parser.sv
module phr_len_parser
  import phr_pkg::*;
#(
  parameter int LEN1_W   = 7,
  parameter int LEN2_W   = 11,
  parameter int MAX_LEN1 = 127,
  parameter int MAX_LEN2 = 2047,
  localparam int LW = (LEN2_W > LEN1_W) ? LEN2_W : LEN1_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic [7:0]    byte_i,
  output logic [LW-1:0] len_o,
  output logic          len_vld_o,
  output logic          len_err_o,
  output logic          fcs2_o,
  output logic          whiten_o,
  output logic          pay_vld_o,
  output logic [LW-1:0] cnt_o,
  output logic          eof_o
);
  phr_st_e       st_q;
  logic          mode_q;
  logic [7:0]    hdr0_q;
  logic [LW-1:0] len_q;
  logic          fcs2_q, wht_q, vld_q, err_q, pay_q, eof_q;

  logic          dec_mode;
  logic [7:0]    dec_b0;
  logic [LW-1:0] dec_len;
  logic          dec_fcs2, dec_wht, dec_err;
  logic          hdr_done, start, pay_byte, last;

  assign start    = valid_i && sof_i;
  assign hdr_done = valid_i && ((sof_i && !mode_i) || (!sof_i && st_q == ST_HDR2));
  assign pay_byte = valid_i && !sof_i && st_q == ST_PAY;
  assign dec_mode = sof_i ? mode_i : mode_q;
  assign dec_b0   = sof_i ? byte_i : hdr0_q;

  phr_hdr_decode #(
    .LEN1_W  (LEN1_W),
    .LEN2_W  (LEN2_W),
    .MAX_LEN1(MAX_LEN1),
    .MAX_LEN2(MAX_LEN2)
  ) u_dec (
    .mode_i  (dec_mode),
    .b0_i    (dec_b0),
    .b1_i    (byte_i),
    .len_o   (dec_len),
    .fcs2_o  (dec_fcs2),
    .whiten_o(dec_wht),
    .err_o   (dec_err)
  );

  phr_pay_cnt #(.LW(LW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start || hdr_done),
    .inc_i (pay_byte),
    .len_i (len_q),
    .cnt_o (cnt_o),
    .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      hdr0_q <= '0;
      len_q  <= '0;
      fcs2_q <= 1'b0;
      wht_q  <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      pay_q  <= 1'b0;
      eof_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      pay_q <= 1'b0;
      eof_q <= 1'b0;
      if (start) begin
        mode_q <= mode_i;
        hdr0_q <= byte_i;
        if (mode_i) st_q <= ST_HDR2;
      end else if (pay_byte) begin
        pay_q <= 1'b1;
        if (last) begin
          eof_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
      end
      if (hdr_done) begin
        if (dec_err) begin
          err_q <= 1'b1;
          st_q  <= ST_IDLE;
        end else begin
          len_q  <= dec_len;
          fcs2_q <= dec_fcs2;
          wht_q  <= dec_wht;
          vld_q  <= 1'b1;
          st_q   <= ST_PAY;
        end
      end
    end
  end

  assign len_o     = len_q;
  assign len_vld_o = vld_q;
  assign len_err_o = err_q;
  assign fcs2_o    = fcs2_q;
  assign whiten_o  = wht_q;
  assign pay_vld_o = pay_q;
  assign eof_o     = eof_q;

  a_r4_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(len_err_o && len_vld_o));
  a_r4_err_keeps_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> $stable(len_o));
  a_r6_eof_on_pay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> pay_vld_o && cnt_o == len_o);
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(cnt_o) && !pay_vld_o && !len_vld_o && !len_err_o);
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PAY |-> cnt_o < len_o);
endmodule

// File: tb/tb_phr_len_parser.sv
module tb_phr_len_parser;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 11;
  localparam int MAX2 = 1500;
  localparam int NV = 12;
  // {mode, rsv, len[10:0], fcs2, whiten, err}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 11'd5,    1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 11'd3,    1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 11'd127,  1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 11'd1,    1'b1, 1'b0, 1'b1},
    {1'b0, 1'b0, 11'd0,    1'b1, 1'b0, 1'b1},
    {1'b1, 1'b0, 11'd6,    1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 11'd3,    1'b0, 1'b0, 1'b1},
    {1'b1, 1'b1, 11'd3,    1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 11'd4,    1'b0, 1'b1, 1'b0},
    {1'b1, 1'b0, 11'd1029, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 11'd1500, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 11'd1501, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, valid = 1'b0, sof = 1'b0;
  logic [7:0] byt = '0;
  logic [LW-1:0] len_o, cnt_o;
  logic len_vld_o, len_err_o, fcs2_o, whiten_o, pay_vld_o, eof_o;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phr_len_parser #(.MAX_LEN2(MAX2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .valid_i(valid), .sof_i(sof),
    .byte_i(byt), .len_o(len_o), .len_vld_o(len_vld_o), .len_err_o(len_err_o),
    .fcs2_o(fcs2_o), .whiten_o(whiten_o), .pay_vld_o(pay_vld_o), .cnt_o(cnt_o),
    .eof_o(eof_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic s, input logic m);
    @(negedge clk);
    byt = b; sof = s; mode = m; valid = 1'b1;
    @(posedge clk); #1;
    valid = 1'b0; sof = 1'b0;
  endtask

  task automatic gap();
    @(negedge clk);
    valid = 1'b0;
    @(posedge clk); #1;
  endtask

  // R3 encoding: h0[3]=fcs2, h0[4]=whiten, header bit 5 = length MSB, bit 15 = LSB
  function automatic logic [15:0] mk_long(input logic [10:0] l, input logic f,
                                          input logic w, input logic r);
    logic [15:0] h;
    h = '0;
    h[0] = r;
    h[3] = f;
    h[4] = w;
    for (int j = 0; j < 11; j++) h[5+j] = l[10-j];
    return h;
  endfunction

  // sends n payload bytes, returns number of per-byte mismatches
  task automatic payload(input int n, input int base, output int bad);
    bad = 0;
    for (int k = 1; k <= n; k++) begin
      send(8'(k), 1'b0, 1'b0);
      if (!pay_vld_o || cnt_o != LW'(base + k) || eof_o != (k == n)) bad++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int bad;
    logic [15:0] h;
    logic [7:0] last_cnt;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(len_o == 0 && cnt_o == 0 && !len_vld_o && !len_err_o && !eof_o && !pay_vld_o
        && !fcs2_o && !whiten_o, "R1 in reset", int'(len_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(len_o == 0 && cnt_o == 0 && !len_vld_o && !pay_vld_o && !fcs2_o,
        "R1 after release", int'(cnt_o), 0);

    // R9: idle bytes without sof
    for (int k = 0; k < 3; k++) begin
      send(8'h05, 1'b0, 1'b0);
      chk(!len_vld_o && !len_err_o && !pay_vld_o && cnt_o == 0, "R9 idle ignore",
          int'(pay_vld_o), 0);
    end

    // vector table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic m, r, f, w, e;
      logic [10:0] l;
      {m, r, l, f, w, e} = VEC[i];
      if (!m) begin
        send({r, l[6:0]}, 1'b1, 1'b0);
      end else begin
        h = mk_long(l, f, w, r);
        send(h[7:0], 1'b1, 1'b1);
        chk(!len_vld_o && !len_err_o, "R3 first byte no strobe", int'(len_vld_o), 0);
        send(h[15:8], 1'b0, 1'b0);
      end
      if (e) begin
        chk(len_err_o && !len_vld_o, "R4 length error", int'(len_err_o), 1);
        send(8'h11, 1'b0, 1'b0);
        chk(!pay_vld_o && !eof_o && cnt_o == 0, "R4 dropped frame", int'(pay_vld_o), 0);
      end else begin
        chk(len_vld_o && !len_err_o && len_o == l, m ? "R3 length" : "R2 length",
            int'(len_o), int'(l));
        chk(fcs2_o == (m ? f : 1'b1) && whiten_o == (m ? w : 1'b0),
            m ? "R3 selectors" : "R2 selectors", int'({fcs2_o, whiten_o}),
            int'(m ? {f, w} : 2'b10));
        payload(int'(l), 0, bad);
        chk(bad == 0, "R5 R6 payload count and eof", bad, 0);
        send(8'h22, 1'b0, 1'b0);
        chk(!pay_vld_o && !eof_o && cnt_o == l, "R6 after eof ignore", int'(cnt_o), int'(l));
      end
    end

    // R7: gaps in payload
    send(8'h04, 1'b1, 1'b0);
    payload(1, 0, bad);
    last_cnt = 8'(cnt_o);
    for (int k = 0; k < 3; k++) begin
      gap();
      chk(cnt_o == 1 && !pay_vld_o && !eof_o, "R7 gap holds", int'(cnt_o), 1);
    end
    payload(3, 1, bad);
    chk(bad == 0 && last_cnt == 1, "R7 resume to eof", bad, 0);

    // R8: sof mid-payload restarts
    send(8'h06, 1'b1, 1'b0);
    payload(2, 0, bad);
    send(8'h03, 1'b1, 1'b0);
    chk(len_vld_o && len_o == 3 && cnt_o == 0 && !eof_o && !pay_vld_o,
        "R8 mid-payload restart", int'(cnt_o), 0);
    payload(3, 0, bad);
    chk(bad == 0, "R8 restarted frame eof", bad, 0);

    // R8: sof collides with the would-be last byte
    send(8'h02, 1'b1, 1'b0);
    payload(1, 0, bad);
    send(8'h05, 1'b1, 1'b0);
    chk(!eof_o && len_vld_o && len_o == 5 && cnt_o == 0, "R8 sof beats eof",
        int'(eof_o), 0);
    payload(5, 0, bad);
    chk(bad == 0, "R8 new frame after collision", bad, 0);

    // R8: sof between the two long-header bytes
    h = mk_long(11'd9, 1'b1, 1'b0, 1'b0);
    send(h[7:0], 1'b1, 1'b1);
    send(8'h07, 1'b1, 1'b0);
    chk(len_vld_o && len_o == 7 && fcs2_o && !whiten_o, "R8 header restart",
        int'(len_o), 7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule